// File: doc/BRIEF.md
# Write Buffer with Read Bypass

This block sits between a cache and the next memory level. It holds stores and displaced dirty blocks in a small FIFO and drains them to memory in the background, so the cache does not have to wait for memory on a store. A read miss does not have to queue behind these pending writes. Its block address is first compared against every live entry. If an entry holds that address, the newest data for it is returned straight from the buffer and memory is never read. If no entry holds that address, the read takes the memory port ahead of any drain.

A read miss that evicts a dirty block presents the victim together with the read. The victim is parked in the buffer in the same cycle the read is accepted. The read then reaches memory first, and the victim is written back later. A store to a block that already has a live entry updates that entry instead of taking a new slot. One exception applies: an entry that memory is accepting in that same cycle is never updated this way.

When a read and a write are accepted in the same cycle, the read sees only the writes accepted in earlier cycles. Memory is assumed to complete requests in the order it grants them.

Top module: `write_buffer`

## Requirements
- R1: After reset the buffer is empty. `wr_ready_o` and `rd_ready_o` are 1, and `mem_req_o` and `rd_resp_valid_o` are 0.
- R2: Accepted writes drain to memory in acceptance order, one per granted write cycle (`mem_req_o`=1, `mem_we_o`=1, `mem_gnt_i`=1). Once the buffer is empty, memory holds the last value written to each address.
- R3: The buffer holds DEPTH (4) distinct block entries. While it is full, `wr_ready_o` and `rd_ready_o` are 0 until an entry drains.
- R4: A write to an address held by a live entry (other than the head being granted in that cycle) overwrites that entry's data. It uses no new slot and causes only one memory write.
- R5: A read whose address matches no entry and not the victim is issued as a memory read (`mem_we_o`=0) in the cycle after acceptance. It is granted before any buffered write drains.
- R6: A read whose address matches a live entry gets that address's newest buffered data on `rd_resp_data_o`, one cycle after acceptance, and no memory read is issued.
- R7: A read accepted with `rd_victim_i`=1 enqueues the victim block in the same cycle. The read is served before the victim is written to memory. A victim whose address equals the read address is forwarded to that read.
- R8: For a read sent to memory, `rd_resp_valid_o` pulses one cycle after `mem_rvalid_i`, carrying the `mem_rdata_i` value from that cycle.
- R9: Only one read is outstanding at a time: `rd_ready_o` is 0 from acceptance until the read's memory transaction completes.
- R10: Under any mix of writes, reads and victim reads, every read returns the most recent value written for its address, or the initial memory value if none was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Store request |
| wr_ready_o | output | 1 | Store accepted when high with wr_valid_i |
| wr_addr_i | input | ADDR_W | Store block address |
| wr_data_i | input | DATA_W | Store data |
| rd_valid_i | input | 1 | Read miss request |
| rd_ready_o | output | 1 | Read accepted when high with rd_valid_i |
| rd_addr_i | input | ADDR_W | Read block address |
| rd_victim_i | input | 1 | Read carries a dirty victim block |
| rd_victim_addr_i | input | ADDR_W | Victim block address |
| rd_victim_data_i | input | DATA_W | Victim block data |
| rd_resp_valid_o | output | 1 | Read data valid, one-cycle pulse |
| rd_resp_data_o | output | DATA_W | Read data |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_gnt_i | input | 1 | Memory accepts the current request |
| mem_rvalid_i | input | 1 | Memory read data valid |
| mem_rdata_i | input | DATA_W | Memory read data |

## Verification
A corrupted pointer, count or entry shows up at the ports in one of three ways. A read returns a stale value when it is served from the buffer or from memory. Memory ends up with a wrong final image after draining. A ready signal is asserted or dropped at the wrong occupancy. A missed address match is exposed by the very next read to that address, because memory still holds the older value. A wrong count shows within a few writes, as an early or late stall, or as a lost or extra drain in the memory write log. The memory model records the order of grants, so a read granted behind a drain, or a victim written before its read, appears on the first transaction after the grant is enabled.

// File: rtl/wb_pkg.sv
package wb_pkg;
  typedef enum logic [1:0] {
    RS_IDLE = 2'd0,
    RS_REQ  = 2'd1,
    RS_WAIT = 2'd2
  } rd_state_e;
endpackage

// File: rtl/wb_store.sv
module wb_store #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enq_i,
  input  logic [ADDR_W-1:0] enq_addr_i,
  input  logic [DATA_W-1:0] enq_data_i,
  input  logic              pop_i,
  input  logic [ADDR_W-1:0] look_addr_i,
  output logic              full_o,
  output logic              empty_o,
  output logic [ADDR_W-1:0] head_addr_o,
  output logic [DATA_W-1:0] head_data_o,
  output logic              look_hit_o,
  output logic [DATA_W-1:0] look_data_o
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [PW-1:0]     head_q, tail_q;
  logic [CW-1:0]     cnt_q;

  logic [PW-1:0]    age_idx [DEPTH];
  logic [DEPTH-1:0] age_live, look_mt, merge_mt;
  logic             merge_hit, push;
  logic [PW-1:0]    merge_idx;

  // age-ordered view: k = 0 is the oldest (head)
  for (genvar k = 0; k < DEPTH; k++) begin : g_age
    localparam bit IS_HEAD = (k == 0);
    assign age_idx[k]  = head_q + PW'(k);
    assign age_live[k] = CW'(k) < cnt_q;
    assign look_mt[k]  = age_live[k] && (addr_q[age_idx[k]] == look_addr_i);
    // the head leaving this cycle must not absorb a new write
    assign merge_mt[k] = age_live[k] && (addr_q[age_idx[k]] == enq_addr_i)
                         && !(IS_HEAD && pop_i);
  end

  always_comb begin
    look_hit_o  = 1'b0;
    look_data_o = '0;
    merge_hit   = 1'b0;
    merge_idx   = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (look_mt[k]) begin
        look_hit_o  = 1'b1;
        look_data_o = data_q[age_idx[k]];
      end
      if (merge_mt[k]) begin
        merge_hit = 1'b1;
        merge_idx = age_idx[k];
      end
    end
  end

  assign push        = enq_i && !merge_hit;
  assign full_o      = (cnt_q == CW'(DEPTH));
  assign empty_o     = (cnt_q == '0);
  assign head_addr_o = addr_q[head_q];
  assign head_data_o = data_q[head_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push)  tail_q <= tail_q + 1'b1;
      if (pop_i) head_q <= head_q + 1'b1;
      cnt_q <= cnt_q + CW'(push) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (enq_i && merge_hit) begin
      data_q[merge_idx] <= enq_data_i;
    end else if (push) begin
      addr_q[tail_q] <= enq_addr_i;
      data_q[tail_q] <= enq_data_i;
    end
  end

  p_pop_nonempty_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enq_i |-> !full_o);
  p_merge_no_grow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enq_i && merge_hit && !pop_i) |=> !empty_o);
endmodule

// File: rtl/wb_mem_arb.sv
module wb_mem_arb #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              rd_req_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              wr_req_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              mem_gnt_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              rd_gnt_o,
  output logic              wr_gnt_o
);
  // fixed priority: a pending read always wins over a drain
  assign mem_req_o   = rd_req_i || wr_req_i;
  assign mem_we_o    = !rd_req_i && wr_req_i;
  assign mem_addr_o  = rd_req_i ? rd_addr_i : wr_addr_i;
  assign mem_wdata_o = wr_data_i;
  assign rd_gnt_o    = rd_req_i && mem_gnt_i;
  assign wr_gnt_o    = mem_we_o && mem_gnt_i;
endmodule

// File: rtl/write_buffer.sv
module write_buffer
  import wb_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_valid_i,
  output logic              rd_ready_o,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              rd_victim_i,
  input  logic [ADDR_W-1:0] rd_victim_addr_i,
  input  logic [DATA_W-1:0] rd_victim_data_i,
  output logic              rd_resp_valid_o,
  output logic [DATA_W-1:0] rd_resp_data_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  rd_state_e         state_q;
  logic [ADDR_W-1:0] rd_addr_q;

  logic              full, empty, buf_hit;
  logic [DATA_W-1:0] buf_data;
  logic [ADDR_W-1:0] head_addr;
  logic [DATA_W-1:0] head_data;
  logic              rd_acc, vic_take, vic_hit, fwd, enq, wr_acc;
  logic [ADDR_W-1:0] enq_addr;
  logic [DATA_W-1:0] enq_data;
  logic              rd_gnt, wr_gnt;

  assign rd_ready_o = (state_q == RS_IDLE) && !full;
  assign rd_acc     = rd_valid_i && rd_ready_o;
  assign vic_take   = rd_acc && rd_victim_i;
  assign wr_ready_o = !full && !vic_take;
  assign wr_acc     = wr_valid_i && wr_ready_o;
  assign enq        = vic_take || wr_acc;
  assign enq_addr   = vic_take ? rd_victim_addr_i : wr_addr_i;
  assign enq_data   = vic_take ? rd_victim_data_i : wr_data_i;
  // the victim is newer than every buffered entry
  assign vic_hit    = rd_victim_i && (rd_victim_addr_i == rd_addr_i);
  assign fwd        = vic_hit || buf_hit;

  wb_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enq_i       (enq),
    .enq_addr_i  (enq_addr),
    .enq_data_i  (enq_data),
    .pop_i       (wr_gnt),
    .look_addr_i (rd_addr_i),
    .full_o      (full),
    .empty_o     (empty),
    .head_addr_o (head_addr),
    .head_data_o (head_data),
    .look_hit_o  (buf_hit),
    .look_data_o (buf_data)
  );

  wb_mem_arb #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arb (
    .rd_req_i    (state_q == RS_REQ),
    .rd_addr_i   (rd_addr_q),
    .wr_req_i    (!empty),
    .wr_addr_i   (head_addr),
    .wr_data_i   (head_data),
    .mem_gnt_i   (mem_gnt_i),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .rd_gnt_o    (rd_gnt),
    .wr_gnt_o    (wr_gnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q         <= RS_IDLE;
      rd_addr_q       <= '0;
      rd_resp_valid_o <= 1'b0;
      rd_resp_data_o  <= '0;
    end else begin
      rd_resp_valid_o <= 1'b0;
      unique case (state_q)
        RS_IDLE: if (rd_acc) begin
          if (fwd) begin
            rd_resp_valid_o <= 1'b1;
            rd_resp_data_o  <= vic_hit ? rd_victim_data_i : buf_data;
          end else begin
            rd_addr_q <= rd_addr_i;
            state_q   <= RS_REQ;
          end
        end
        RS_REQ: if (rd_gnt) state_q <= RS_WAIT;
        RS_WAIT: if (mem_rvalid_i) begin
          rd_resp_valid_o <= 1'b1;
          rd_resp_data_o  <= mem_rdata_i;
          state_q         <= RS_IDLE;
        end
        default: state_q <= RS_IDLE;
      endcase
    end
  end

  p_read_first_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RS_REQ) |-> (mem_req_o && !mem_we_o));
  p_miss_to_mem_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc && !fwd) |=> (mem_req_o && !mem_we_o));
  p_fwd_no_mem_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc && fwd) |=> (rd_resp_valid_o && !(mem_req_o && !mem_we_o)));
  p_victim_parked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vic_take |=> mem_req_o);
  p_resp_after_rvalid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == RS_WAIT) && mem_rvalid_i) |=> rd_resp_valid_o);
  p_one_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != RS_IDLE) |-> !rd_ready_o);
endmodule

// File: tb/tb_write_buffer.sv
module tb_write_buffer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_valid_i = 1'b0, rd_valid_i = 1'b0, rd_victim_i = 1'b0;
  logic [3:0] wr_addr_i = '0, rd_addr_i = '0, rd_victim_addr_i = '0;
  logic [7:0] wr_data_i = '0, rd_victim_data_i = '0;
  logic       wr_ready_o, rd_ready_o, rd_resp_valid_o;
  logic [7:0] rd_resp_data_o, mem_wdata_o, mem_rdata_i;
  logic       mem_req_o, mem_we_o, mem_gnt_i, mem_rvalid_i;
  logic [3:0] mem_addr_o;

  always #5 clk_i = ~clk_i;

  write_buffer #(.DEPTH(4), .ADDR_W(4), .DATA_W(8)) dut (.*);

  // memory model
  int         gnt_mode = 0;
  logic [15:0] glfsr;
  logic [7:0] mem_q [16];
  logic [7:0] ref_q [16];
  logic [3:0] wr_log [1024];
  int         wr_log_n, mem_rd_cnt, rd_at_wr;
  int         rlat;
  logic [7:0] rbuf;
  int         checks = 0, errors = 0;

  assign mem_gnt_i    = (gnt_mode == 1) || (gnt_mode == 2 && glfsr[0]);
  assign mem_rvalid_i = (rlat == 1);
  assign mem_rdata_i  = rbuf;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      for (int a = 0; a < 16; a++) mem_q[a] <= 8'(a * 17 + 3);
      wr_log_n <= 0; mem_rd_cnt <= 0; rd_at_wr <= -1; rlat <= 0; rbuf <= '0;
      glfsr <= 16'hACE1;
    end else begin
      glfsr <= {glfsr[14:0], glfsr[15] ^ glfsr[13] ^ glfsr[12] ^ glfsr[10]};
      if (mem_req_o && mem_gnt_i && mem_we_o) begin
        mem_q[mem_addr_o] <= mem_wdata_o;
        wr_log[wr_log_n[9:0]] <= mem_addr_o;
        wr_log_n <= wr_log_n + 1;
      end
      if (mem_req_o && mem_gnt_i && !mem_we_o) begin
        rlat <= 2; rbuf <= mem_q[mem_addr_o];
        mem_rd_cnt <= mem_rd_cnt + 1; rd_at_wr <= wr_log_n;
      end else if (rlat != 0) begin
        rlat <= rlat - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [3:0] a, input logic [7:0] d);
    wr_valid_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    while (!wr_ready_o) @(negedge clk_i);
    @(posedge clk_i);
    ref_q[a] = d;
    @(negedge clk_i);
    wr_valid_i = 1'b0;
  endtask

  task automatic do_rd(input logic [3:0] a, input bit vic, input logic [3:0] va,
                       input logic [7:0] vd, input int gnt_after,
                       output int lat, output bit prev_rv, output int mrd);
    logic [7:0] exp;
    int m0;
    rd_valid_i = 1'b1; rd_addr_i = a; rd_victim_i = vic;
    rd_victim_addr_i = va; rd_victim_data_i = vd;
    while (!rd_ready_o) @(negedge clk_i);
    @(posedge clk_i);
    m0 = mem_rd_cnt;
    if (vic) ref_q[va] = vd;
    exp = ref_q[a];
    @(negedge clk_i);
    rd_valid_i = 1'b0; rd_victim_i = 1'b0;
    if (gnt_after >= 0) gnt_mode = gnt_after;
    lat = 1; prev_rv = 1'b0;
    if (!rd_resp_valid_o) chk(rd_ready_o == 1'b0, "R9 busy read", int'(rd_ready_o), 0);
    while (!rd_resp_valid_o && lat < 200) begin
      prev_rv = mem_rvalid_i;
      @(negedge clk_i);
      lat++;
    end
    mrd = mem_rd_cnt - m0;
    chk(rd_resp_data_o == exp, "R10 read data", int'(rd_resp_data_o), int'(exp));
  endtask

  task automatic wait_idle();
    gnt_mode = 1;
    @(negedge clk_i);
    while (mem_req_o || rlat != 0) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lat, mrd, base;
    bit prv;
    logic [15:0] s;
    for (int a = 0; a < 16; a++) ref_q[a] = 8'(a * 17 + 3);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    chk(wr_ready_o == 1'b1, "R1 wr_ready", int'(wr_ready_o), 1);
    chk(rd_ready_o == 1'b1, "R1 rd_ready", int'(rd_ready_o), 1);
    chk(mem_req_o == 1'b0, "R1 mem_req", int'(mem_req_o), 0);
    chk(rd_resp_valid_o == 1'b0, "R1 resp", int'(rd_resp_valid_o), 0);

    // R3 / R2: fill, stall, drain in order
    gnt_mode = 0;
    base = wr_log_n;
    do_wr(4'd1, 8'h11); do_wr(4'd2, 8'h22); do_wr(4'd3, 8'h33); do_wr(4'd4, 8'h44);
    chk(wr_ready_o == 1'b0, "R3 full stall", int'(wr_ready_o), 0);
    chk(rd_ready_o == 1'b0, "R3 full read stall", int'(rd_ready_o), 0);
    wait_idle();
    chk(wr_log_n - base == 4, "R2 drain count", wr_log_n - base, 4);
    for (int i = 0; i < 4; i++)
      chk(wr_log[base + i] == 4'(i + 1), "R2 drain order", int'(wr_log[base + i]), i + 1);

    // R4: merge
    gnt_mode = 0;
    base = wr_log_n;
    do_wr(4'd5, 8'h01); do_wr(4'd6, 8'h02); do_wr(4'd5, 8'h03); do_wr(4'd7, 8'h04);
    chk(wr_ready_o == 1'b1, "R4 merged slot free", int'(wr_ready_o), 1);
    do_wr(4'd8, 8'h05);
    chk(wr_ready_o == 1'b0, "R4 full after merge", int'(wr_ready_o), 0);
    wait_idle();
    chk(wr_log_n - base == 4, "R4 one write per block", wr_log_n - base, 4);
    chk(mem_q[5] == 8'h03, "R4 merged value", int'(mem_q[5]), 3);

    // R6: forwarding, newest data, no memory read
    gnt_mode = 0;
    do_wr(4'd9, 8'h55); do_wr(4'd10, 8'h66); do_wr(4'd9, 8'h77);
    do_rd(4'd9, 1'b0, 4'd0, 8'd0, -1, lat, prv, mrd);
    chk(lat == 1, "R6 forward latency", lat, 1);
    chk(mrd == 0, "R6 no memory read", mrd, 0);
    wait_idle();

    // R5 / R8: read miss ahead of pending writes
    gnt_mode = 0;
    do_wr(4'd11, 8'h81); do_wr(4'd12, 8'h82);
    base = wr_log_n;
    do_rd(4'd13, 1'b0, 4'd0, 8'd0, 1, lat, prv, mrd);
    chk(mrd == 1, "R5 memory read issued", mrd, 1);
    chk(rd_at_wr == base, "R5 read before drains", rd_at_wr, base);
    chk(prv == 1'b1, "R8 resp after rvalid", int'(prv), 1);
    wait_idle();
    chk(wr_log[base] == 4'd11, "R5 drains follow", int'(wr_log[base]), 11);

    // R7: victim parked, read goes first
    gnt_mode = 0;
    base = wr_log_n;
    do_rd(4'd14, 1'b1, 4'd15, 8'h99, 1, lat, prv, mrd);
    chk(rd_at_wr == base, "R7 read before victim", rd_at_wr, base);
    wait_idle();
    chk(wr_log[base] == 4'd15, "R7 victim written", int'(wr_log[base]), 15);
    chk(mem_q[15] == 8'h99, "R7 victim data", int'(mem_q[15]), 153);

    // R7: victim with the read's own address is forwarded
    gnt_mode = 0;
    do_rd(4'd3, 1'b1, 4'd3, 8'h5A, -1, lat, prv, mrd);
    chk(lat == 1 && mrd == 0, "R7 victim forward", lat, 1);
    wait_idle();

    // R10: mixed sweep with irregular grants
    gnt_mode = 2;
    s = 16'h1D2B;
    for (int i = 0; i < 400; i++) begin
      s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
      case (s[1:0])
        2'd0, 2'd1: do_wr(s[5:2], s[15:8]);
        2'd2: do_rd(s[5:2], 1'b0, 4'd0, 8'd0, -1, lat, prv, mrd);
        default: do_rd(s[5:2], 1'b1, s[9:6], s[15:8] ^ 8'hA5, -1, lat, prv, mrd);
      endcase
      if (s[1:0] == 2'd3) gnt_mode = 2;
    end
    wait_idle();
    for (int a = 0; a < 16; a++)
      chk(mem_q[a] == ref_q[a], "R2 final image", int'(mem_q[a]), int'(ref_q[a]));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule